// File: doc/BRIEF.md
# Delta Sample Fetch Controller

This block runs the memory side of a one-bit delta sample playback channel. Software programs a start-address code, a length code, a loop flag and an interrupt enable, then sets an enable bit in the status register. The controller keeps a current address and a count of bytes still to fetch, and holds one fetched byte in a buffer. Whenever that buffer is empty and bytes remain, it raises a DMA read request. The byte that comes back is kept until the output unit takes it on a rate tick.

When the last byte of a sample is fetched, the channel does one of three things. With looping on, it reloads its address and count from the registers. With looping off and the interrupt enabled, it raises an interrupt flag. Otherwise it simply goes idle. A status port shows at all times whether bytes remain and whether the interrupt flag is set. The rate timer itself and the bit-level output stage live outside the block; they meet it through the 4-bit rate code and the tick input.

Register selects on `reg_wr_sel`:
- 0 is control: bit 7 is the interrupt enable, bit 6 is the loop flag, and bits 3:0 are the rate code.
- 1 is the start-address code.
- 2 is the length code.
- 3 is status: bit 4 is the enable.

Top module: `delta_fetch_ctrl`

## Requirements
- R1: `stat_rdata` bit 4 is 1 exactly while the bytes-remaining count is nonzero, and 0 once the sample has ended. `stat_rdata` bit 7 mirrors the interrupt flag. All other status bits read 0.
- R2: A status write with bit 4 set while no bytes remain restarts playback. On the next cycle the address is $C000 + 64 × start code and the count is 16 × length code + 1. The same write while bytes remain changes nothing.
- R3: A status write with bit 4 clear sets the count to zero on the next cycle. No new request is raised afterwards.
- R4: Writing the length code does not change the count of a sample already playing. A length code of 0 yields exactly one fetch.
- R5: On the last fetch with looping on, the address and count are reloaded from the registers and the interrupt flag is left alone. Clearing the loop flag mid-pass lets that pass finish and then end.
- R6: The interrupt flag is set when the last byte is fetched with looping off and the interrupt enabled. It stays set through status reads. It is cleared by any status write, or by a control write with bit 7 clear; a clear wins over a set in the same cycle.
- R7: With the buffer empty, bytes remaining and no hold-off pending, `dma_req` rises on the next cycle. It stays high until a cycle with `dma_ack`, which loads `dma_rdata` into the buffer. Only one request is outstanding at a time.
- R8: Advancing the address past $FFFF gives $8000, so `dma_addr` bit 15 is always 1.
- R9: A restart blocks new requests for 3 cycles if written on an even cycle, or 4 if written on an odd one. Cycle parity starts at 0 after reset and toggles every clock, so `dma_req` first shows 5 or 6 cycles after the writing cycle.
- R10: A rate tick with the buffer full pulses `smp_strobe` on the next cycle with the byte on `smp_data`, and empties the buffer. A tick with the buffer empty does nothing.
- R11: After reset, `dma_req`, `irq`, `smp_strobe` and `stat_rdata` are 0, and `dma_addr` is $C000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (0 control, 1 start, 2 length, 3 status) |
| reg_wr_data | input | 8 | Register write data |
| stat_rdata | output | 8 | Status: bit 7 interrupt flag, bit 4 bytes remain |
| rate_sel | output | 4 | Rate code for the external timer |
| rate_tick | input | 1 | Output unit takes the buffered byte |
| smp_strobe | output | 1 | Pulse: a byte was handed to the output unit |
| smp_data | output | 8 | Byte handed over on the strobe |
| dma_req | output | 1 | DMA read request |
| dma_addr | output | 16 | Address of the requested byte |
| dma_ack | input | 1 | Request served this cycle |
| dma_rdata | input | 8 | Byte returned with the acknowledge |
| irq | output | 1 | Interrupt flag |

## Verification
A count that is off by one surfaces at `stat_rdata` bit 4 on the cycle the sample ends. It also surfaces as a missing or extra request, which shows one cycle after the buffer empties. A wrong address or a bad wrap shows on `dma_addr` on the first request after the faulty increment. A missed loop reload shows as a sample that ends, and a misplaced interrupt decision shows on `irq` one cycle after the final acknowledge. Because of that, the bench compares every output against its model on every cycle, and in addition measures the restart hold-off latency on both cycle parities.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 16;
    localparam int CODE_W      = 8;
    localparam int RATE_W      = 4;
    localparam int LEN_SHIFT   = 4;
    localparam int BASE_SHIFT  = 6;
    localparam int LEN_W       = CODE_W + LEN_SHIFT;
    localparam logic [ADDR_W-1:0] START_BASE = 16'hC000;
    localparam logic [ADDR_W-1:0] WRAP_BASE  = 16'h8000;

    localparam int CTRL_IRQ_BIT  = 7;
    localparam int CTRL_LOOP_BIT = 6;
    localparam int STAT_EN_BIT   = 4;
    localparam int STAT_IRQ_BIT  = 7;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_SIZE = 2'd2,
        SEL_STAT = 2'd3
    } dsf_sel_e;

    typedef struct packed {
        logic              irq_en;
        logic              loop;
        logic [RATE_W-1:0] rate;
        logic [CODE_W-1:0] base_code;
        logic [CODE_W-1:0] size_code;
    } dsf_cfg_t;

    typedef struct packed {
        logic en_set;
        logic kill;
        logic irq_clr;
    } dsf_evt_t;

    function automatic logic [ADDR_W-1:0] start_addr(input logic [CODE_W-1:0] code);
        return START_BASE + (ADDR_W'(code) << BASE_SHIFT);
    endfunction

    function automatic logic [LEN_W-1:0] run_len(input logic [CODE_W-1:0] code);
        return (LEN_W'(code) << LEN_SHIFT) + LEN_W'(1);
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return (a == {ADDR_W{1'b1}}) ? WRAP_BASE : a + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/dsf_regs.sv
module dsf_regs
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output dsf_cfg_t          cfg,
    output dsf_evt_t          evt
);
    dsf_sel_e sel;
    logic     unused_wr_bit;

    assign sel           = dsf_sel_e'(wr_sel);
    assign unused_wr_bit = wr_data[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    cfg.irq_en <= wr_data[CTRL_IRQ_BIT];
                    cfg.loop   <= wr_data[CTRL_LOOP_BIT];
                    cfg.rate   <= wr_data[RATE_W-1:0];
                end
                SEL_BASE: cfg.base_code <= wr_data;
                SEL_SIZE: cfg.size_code <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        evt         = '0;
        evt.en_set  = wr_en && (sel == SEL_STAT) &&  wr_data[STAT_EN_BIT];
        evt.kill    = wr_en && (sel == SEL_STAT) && !wr_data[STAT_EN_BIT];
        evt.irq_clr = wr_en && ((sel == SEL_STAT) ||
                               ((sel == SEL_CTRL) && !wr_data[CTRL_IRQ_BIT]));
    end
endmodule

// File: rtl/dsf_counters.sv
module dsf_counters
    import dsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dsf_cfg_t          cfg,
    input  dsf_evt_t          evt,
    input  logic              fetch_done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              remain_nz,
    output logic              irq_flag,
    output logic              restart
);
    logic [LEN_W-1:0] remain;
    logic             counted;
    logic             last_byte;

    assign remain_nz = (remain != '0);
    assign restart   = evt.en_set && !remain_nz;
    assign counted   = fetch_done && remain_nz;
    assign last_byte = counted && (remain == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (evt.kill) begin
            remain <= '0;
        end else if (restart) begin
            remain <= run_len(cfg.size_code);
        end else if (last_byte && cfg.loop) begin
            remain <= run_len(cfg.size_code);
        end else if (counted) begin
            remain <= remain - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= START_BASE;
        end else if (restart || (last_byte && cfg.loop)) begin
            cur_addr <= start_addr(cfg.base_code);
        end else if (counted) begin
            cur_addr <= step_addr(cur_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
        end else if (evt.irq_clr) begin
            irq_flag <= 1'b0;
        end else if (last_byte && !cfg.loop && cfg.irq_en) begin
            irq_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/dsf_fetch.sv
module dsf_fetch
    import dsf_pkg::*;
#(
    parameter bit PHASED_DELAY = 1'b1,
    parameter int DELAY_EVEN   = 3,
    parameter int DELAY_ODD    = 4,
    localparam int HOLD_W      = $clog2(DELAY_ODD + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              remain_nz,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic              rate_tick,
    output logic              dma_req,
    output logic              fetch_done,
    output logic              smp_strobe,
    output logic [DATA_W-1:0] smp_data
);
    logic              phase;
    logic [HOLD_W-1:0] hold;
    logic [HOLD_W-1:0] hold_load;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              take;

    generate
        if (PHASED_DELAY) begin : g_phased
            assign hold_load = phase ? HOLD_W'(DELAY_ODD) : HOLD_W'(DELAY_EVEN);
        end else begin : g_fixed
            assign hold_load = HOLD_W'(DELAY_ODD);
        end
    endgenerate

    assign fetch_done = dma_req && dma_ack;
    assign take       = rate_tick && buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            hold  <= '0;
        end else begin
            phase <= ~phase;
            if (restart)
                hold <= hold_load;
            else if (hold != '0)
                hold <= hold - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dma_req <= 1'b0;
        else if (dma_req)
            dma_req <= !dma_ack;
        else
            dma_req <= !buf_full && remain_nz && (hold == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full   <= 1'b0;
            buf_data   <= '0;
            smp_strobe <= 1'b0;
            smp_data   <= '0;
        end else begin
            smp_strobe <= take;
            if (take)
                smp_data <= buf_data;
            if (fetch_done) begin
                buf_full <= 1'b1;
                buf_data <= dma_rdata;
            end else if (take) begin
                buf_full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/delta_fetch_ctrl.sv
module delta_fetch_ctrl
    import dsf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_wr_sel,
    input  logic [7:0]  reg_wr_data,
    output logic [7:0]  stat_rdata,
    output logic [3:0]  rate_sel,
    input  logic        rate_tick,
    output logic        smp_strobe,
    output logic [7:0]  smp_data,
    output logic        dma_req,
    output logic [15:0] dma_addr,
    input  logic        dma_ack,
    input  logic [7:0]  dma_rdata,
    output logic        irq
);
    dsf_cfg_t cfg;
    dsf_evt_t evt;
    logic     remain_nz;
    logic     irq_flag;
    logic     restart;
    logic     fetch_done;

    dsf_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .cfg     (cfg),
        .evt     (evt)
    );

    dsf_counters u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .evt        (evt),
        .fetch_done (fetch_done),
        .cur_addr   (dma_addr),
        .remain_nz  (remain_nz),
        .irq_flag   (irq_flag),
        .restart    (restart)
    );

    dsf_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .remain_nz  (remain_nz),
        .dma_ack    (dma_ack),
        .dma_rdata  (dma_rdata),
        .rate_tick  (rate_tick),
        .dma_req    (dma_req),
        .fetch_done (fetch_done),
        .smp_strobe (smp_strobe),
        .smp_data   (smp_data)
    );

    always_comb begin
        stat_rdata               = '0;
        stat_rdata[STAT_EN_BIT]  = remain_nz;
        stat_rdata[STAT_IRQ_BIT] = irq_flag;
    end

    assign rate_sel = cfg.rate;
    assign irq      = irq_flag;
endmodule

// File: rtl/delta_fetch_ctrl_chk.sv
module delta_fetch_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr_en,
    input logic [1:0]  reg_wr_sel,
    input logic [7:0]  reg_wr_data,
    input logic [7:0]  stat_rdata,
    input logic        rate_tick,
    input logic        smp_strobe,
    input logic        dma_req,
    input logic [15:0] dma_addr,
    input logic        dma_ack,
    input logic        irq
);
    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_ack) |=> dma_req);

    assert_req_needs_bytes_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_req) |-> $past(stat_rdata[4]));

    assert_addr_upper_R8: assert property (@(posedge clk) disable iff (rst)
        dma_addr[15]);

    assert_kill_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_sel == 2'd3 && !reg_wr_data[4]) |=> !stat_rdata[4]);

    assert_stat_wr_clears_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_sel == 2'd3) |=> !irq);

    assert_irq_off_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_sel == 2'd0 && !reg_wr_data[7]) |=> !irq);

    assert_restart_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_sel == 2'd3 && reg_wr_data[4] && !stat_rdata[4] && !dma_req)
        |=> !dma_req);

    assert_strobe_from_tick_R10: assert property (@(posedge clk) disable iff (rst)
        smp_strobe |-> $past(rate_tick));

    assert_stat_spare_bits_R1: assert property (@(posedge clk) disable iff (rst)
        stat_rdata[6:5] == 2'b00 && stat_rdata[3:0] == 4'h0);
endmodule

bind delta_fetch_ctrl delta_fetch_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .stat_rdata  (stat_rdata),
    .rate_tick   (rate_tick),
    .smp_strobe  (smp_strobe),
    .dma_req     (dma_req),
    .dma_addr    (dma_addr),
    .dma_ack     (dma_ack),
    .irq         (irq)
);

// File: tb/delta_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module delta_fetch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd0;
    logic [7:0]  reg_wr_data = 8'd0;
    logic [7:0]  stat_rdata;
    logic [3:0]  rate_sel;
    logic        rate_tick = 1'b0;
    logic        smp_strobe;
    logic [7:0]  smp_data;
    logic        dma_req;
    logic [15:0] dma_addr;
    logic        dma_ack = 1'b0;
    logic [7:0]  dma_rdata = 8'd0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fetches = 0;
    int ack_cnt = 0;
    int tick_cnt = 0;

    // reference model state
    int m_addr, m_rem, m_full, m_buf, m_req, m_irq, m_hold, m_par;
    int m_irqen, m_loop, m_start, m_len, m_rate, m_ostb, m_odata;

    always #5 clk = ~clk;

    delta_fetch_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .stat_rdata(stat_rdata), .rate_sel(rate_sel),
        .rate_tick(rate_tick), .smp_strobe(smp_strobe), .smp_data(smp_data),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_ack(dma_ack),
        .dma_rdata(dma_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model, updated on every clock from the sampled inputs
    always @(posedge clk) begin
        if (rst) begin
            m_addr = 'hC000; m_rem = 0; m_full = 0; m_buf = 0; m_req = 0; m_irq = 0;
            m_hold = 0; m_par = 0; m_irqen = 0; m_loop = 0; m_start = 0; m_len = 0;
            m_rate = 0; m_ostb = 0; m_odata = 0;
            cyc = 0;
        end else begin
            bit fd, wst, wct, rs, kl, cnt, tk;
            int orem;
            fd  = (m_req != 0) && dma_ack;
            wst = reg_wr_en && reg_wr_sel == 2'd3;
            wct = reg_wr_en && reg_wr_sel == 2'd0;
            rs  = wst && reg_wr_data[4] && m_rem == 0;
            kl  = wst && !reg_wr_data[4];
            orem = m_rem;
            cnt = fd && orem != 0;
            tk  = rate_tick && m_full != 0;
            if (fd) fetches++;
            if (wst || (wct && !reg_wr_data[7])) m_irq = 0;
            else if (cnt && orem == 1 && m_loop == 0 && m_irqen != 0) m_irq = 1;
            if (kl) m_rem = 0;
            else if (rs) m_rem = m_len * 16 + 1;
            else if (cnt) m_rem = (orem == 1 && m_loop != 0) ? m_len * 16 + 1 : orem - 1;
            if (rs || (cnt && orem == 1 && m_loop != 0)) m_addr = 'hC000 + m_start * 64;
            else if (cnt) m_addr = (m_addr == 'hFFFF) ? 'h8000 : m_addr + 1;
            if (m_req != 0) m_req = dma_ack ? 0 : 1;
            else m_req = (m_full == 0 && orem != 0 && m_hold == 0) ? 1 : 0;
            m_ostb = tk;
            if (tk) m_odata = m_buf;
            if (fd) begin m_full = 1; m_buf = dma_rdata; end
            else if (tk) m_full = 0;
            if (rs) m_hold = m_par ? 4 : 3;
            else if (m_hold > 0) m_hold--;
            m_par = m_par ^ 1;
            if (reg_wr_en) begin
                case (reg_wr_sel)
                    2'd0: begin m_irqen = reg_wr_data[7]; m_loop = reg_wr_data[6]; m_rate = reg_wr_data[3:0]; end
                    2'd1: m_start = reg_wr_data;
                    2'd2: m_len = reg_wr_data;
                    default: ;
                endcase
            end
            cyc++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(dma_req == m_req[0], "R7 dma_req", dma_req, m_req);
            check(dma_addr == m_addr[15:0], "R8 dma_addr", dma_addr, m_addr);
            check(stat_rdata == {m_irq[0], 2'b00, (m_rem != 0), 4'h0}, "R1 stat_rdata",
                  stat_rdata, {m_irq[0], 2'b00, (m_rem != 0), 4'h0});
            check(irq == m_irq[0], "R6 irq", irq, m_irq);
            check(rate_sel == m_rate[3:0], "R2 rate_sel", rate_sel, m_rate);
            check(smp_strobe == m_ostb[0], "R10 smp_strobe", smp_strobe, m_ostb);
            if (m_ostb != 0) check(smp_data == m_odata[7:0], "R10 smp_data", smp_data, m_odata);
        end
    end

    // DMA responder and rate tick source
    always @(negedge clk) begin
        dma_ack = 1'b0;
        if (dma_req) begin
            ack_cnt++;
            if (ack_cnt == 2) begin
                dma_ack = 1'b1;
                dma_rdata = dma_addr[7:0] ^ 8'h5A;
                ack_cnt = 0;
            end
        end else begin
            ack_cnt = 0;
        end
        tick_cnt++;
        rate_tick = (tick_cnt % 5 == 4);
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_end(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (!stat_rdata[4]) break;
        end
    endtask

    task automatic restart_lat(input int want_par);
        int wcyc, lat, exp;
        idle(20);
        @(negedge clk);
        while (cyc % 2 != want_par) @(negedge clk);
        wcyc = cyc;
        reg_wr_en = 1'b1; reg_wr_sel = 2'd3; reg_wr_data = 8'h10;
        @(negedge clk);
        reg_wr_en = 1'b0;
        lat = -1;
        for (int i = 0; i < 20; i++) begin
            if (dma_req) begin lat = cyc - wcyc; break; end
            @(negedge clk);
        end
        exp = (want_par != 0) ? 6 : 5;
        check(lat == exp, "R9 restart hold-off", lat, exp);
    endtask

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(dma_req == 1'b0 && irq == 1'b0 && smp_strobe == 1'b0, "R11 reset outputs", {dma_req, irq, smp_strobe}, 0);
        check(stat_rdata == 8'h00, "R11 reset status", stat_rdata, 0);
        check(dma_addr == 16'hC000, "R11 reset addr", dma_addr, 16'hC000);

        // R2 R4: length code 0 gives one byte, interrupt raised (R6)
        wr(2'd0, 8'h80); wr(2'd1, 8'h10); wr(2'd2, 8'h00);
        f0 = fetches;
        wr(2'd3, 8'h10);
        check(stat_rdata[4] == 1'b1, "R2 restart sets active", stat_rdata[4], 1);
        check(dma_addr == 16'hC400, "R2 start address", dma_addr, 16'hC400);
        wait_end(200);
        idle(30);
        check(fetches - f0 == 1, "R4 zero length one fetch", fetches - f0, 1);
        check(irq == 1'b1, "R6 irq at end", irq, 1);
        idle(10);
        check(irq == 1'b1, "R6 status observation keeps irq", irq, 1);
        wr(2'd3, 8'h00);
        check(irq == 1'b0, "R6 status write clears", irq, 0);

        // R4: length write and repeat enable during playback do not alter the count
        wr(2'd0, 8'h00); wr(2'd1, 8'h01); wr(2'd2, 8'h02);
        f0 = fetches;
        wr(2'd3, 8'h10);
        idle(5);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h10);
        wait_end(2000);
        idle(20);
        check(fetches - f0 == 33, "R4 R2 count unchanged by writes", fetches - f0, 33);

        // R3: disable mid-sample
        wr(2'd2, 8'h04);
        wr(2'd3, 8'h10);
        idle(25);
        wr(2'd3, 8'h00);
        check(stat_rdata[4] == 1'b0, "R3 disable clears count", stat_rdata[4], 0);
        f0 = fetches;
        idle(40);
        check(fetches - f0 <= 1, "R3 no new fetches after disable", fetches - f0, 1);

        // R5: loop, no irq, then loop cleared lets the pass end
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'hC0);
        f0 = fetches;
        wr(2'd3, 8'h10);
        idle(120);
        check(fetches - f0 >= 5, "R5 loop keeps fetching", fetches - f0, 5);
        check(irq == 1'b0 && stat_rdata[4], "R5 loop no irq and active", {irq, stat_rdata[4]}, 1);
        wr(2'd0, 8'h80);
        wait_end(200);
        idle(5);
        check(stat_rdata[4] == 1'b0 && irq == 1'b1, "R5 pass ends after loop cleared", {irq, stat_rdata[4]}, 2);
        wr(2'd0, 8'h00);
        check(irq == 1'b0, "R6 irq enable off clears", irq, 0);

        // R8: wrap past the top of memory
        wr(2'd1, 8'hFF); wr(2'd2, 8'h04);
        wr(2'd3, 8'h10);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                if (dma_req && dma_addr == 16'h8000) seen = 1'b1;
                if (!stat_rdata[4]) break;
            end
            check(seen, "R8 address wraps to 8000", seen, 1);
        end

        // R9: hold-off latency on both parities
        wr(2'd2, 8'h00);
        restart_lat(0);
        wait_end(200);
        restart_lat(1);
        wait_end(200);
        idle(20);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule